// File: doc/BRIEF.md
# Fast PWM Timer with Selectable Period Limit

An 8-bit up-counter drives two waveform channels, A and B, each with its own output pin. A mode field picks where the counter turns round. In the fixed mode it runs from 0 to 0xFF. In the compare-limited mode it runs from 0 to the active value of compare register A. In the compare-limited mode, register A sets the PWM period and channel B sets the duty inside that period. Channel A can then only toggle, which gives a 50% square wave.

Each channel compares the count against its own active compare value. A 2-bit action field decides what the pin does on a match and at the wrap: it can stay off, toggle, run non-inverted or run inverted. Software writes to the compare registers land in buffers. While the counter runs, the buffers move to the active comparators only at the period limit, so a running period is never disturbed. The block keeps three sticky event flags: one for overflow and one for each channel's match. Software clears a flag by writing a 1 to its bit.

Register map (write-only, `wr_addr`): 0 holds the mode in bits [2:0]. 1 holds the actions, A in bits [1:0] and B in bits [3:2]. 2 is the buffer for compare A and 3 is the buffer for compare B. 4 is the flag clear: bit 0 clears the overflow flag, bit 1 the A flag and bit 2 the B flag.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count, both pins and all three flags are 0, the mode is 3'b000 and both actions are 2'b00.
- R2: In mode 3'b011 the count steps by one each cycle from 0 to 0xFF, and the cycle after 0xFF it reads 0.
- R3: In mode 3'b111 the count steps by one each cycle, and the cycle after it equals the active compare A value it reads 0.
- R4: In any mode other than 3'b011 or 3'b111 the count is held at 0, no flag is set and no pin changes.
- R5: The overflow flag is set in the cycle after the count equals the active period limit.
- R6: With action 2'b10 the pin goes to 1 in the first cycle the count reads 0 and goes to 0 in the first cycle after the count equals the channel's compare value. A compare value equal to the limit keeps the pin at 1.
- R7: With action 2'b11 the pin follows the complement of the R6 rule: it goes to 0 at the wrap and to 1 after the match.
- R8: With action 2'b01 on channel A in mode 3'b111, pin A inverts in the cycle after each match. A compare A value of 0 makes pin A alternate on every cycle.
- R9: Action 2'b01 on channel B, or on channel A in mode 3'b011, drives that pin to 0.
- R10: With action 2'b00 the pin is 0, but a match still sets the channel's flag.
- R11: While the counter runs, a compare write takes effect only in the period that follows the next time the limit is reached. While the counter is halted, the write reaches the active comparator two cycles later.
- R12: Flags stay set until software writes a 1 to their bit at address 4. A flag event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| count | output | 8 | Current counter value |
| pin_a | output | 1 | Channel A waveform |
| pin_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_a_flag | output | 1 | Sticky channel A match flag |
| cmp_b_flag | output | 1 | Sticky channel B match flag |

## Verification
Directed runs fix the corner points of the waveform.

- A short period with a small B value tells the duty rule apart from an off-by-one.
- A B value equal to the limit tests the priority of the wrap over the match.
- A compare A value of 0 exposes the fastest toggle rate.
- A B write in mid-period shows whether the buffer is honoured.

A seeded random phase then mixes mode changes, action changes, compare writes and flag clears. It compares every output on every cycle against a cycle model kept in the bench. This catches mistakes in how the mode, action and update orderings interact.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;
    localparam int ADDR_W = 3;

    localparam logic [2:0] MODE_FIXED = 3'b011;
    localparam logic [2:0] MODE_CMPA  = 3'b111;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_ACT  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_BUFA = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_BUFB = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd4;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'b00,
        ACT_TOG    = 2'b01,
        ACT_NONINV = 2'b10,
        ACT_INV    = 2'b11
    } act_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             run,
    output logic             at_top,
    output logic             ovf_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic [CNT_W-1:0] top;

    always_comb begin
        s_d    = s_q;
        run    = (mode == MODE_FIXED) || (mode == MODE_CMPA);
        top    = (mode == MODE_CMPA) ? cmp_a : CNT_MAX;
        at_top = run && (s_q.cnt == top);
        if (!run) begin
            s_d.cnt = '0;
        end else if (at_top) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (at_top) begin
            s_d.ovf = 1'b1;
        end else if (ovf_clr) begin
            s_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count    = s_q.cnt;
    assign ovf_flag = s_q.ovf;
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CNT_W-1:0]              wr_data,
    input  logic                          run,
    input  logic                          at_top,
    output logic [2:0]                    mode,
    output logic [NUM_CH-1:0][1:0]        act,
    output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_act
);
    typedef struct packed {
        logic [2:0]                   mode;
        logic [NUM_CH-1:0][1:0]       act;
        logic [NUM_CH-1:0][CNT_W-1:0] buf_v;
        logic [NUM_CH-1:0][CNT_W-1:0] cmp;
    } reg_st_t;

    reg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // Buffered values reach the comparators at the limit, or at once while halted.
        if (!run || at_top) begin
            s_d.cmp = s_q.buf_v;
        end
        if (wr_en) begin
            case (wr_addr)
                ADDR_MODE: s_d.mode     = wr_data[2:0];
                ADDR_ACT:  s_d.act      = wr_data[2*NUM_CH-1:0];
                ADDR_BUFA: s_d.buf_v[0] = wr_data;
                ADDR_BUFB: s_d.buf_v[1] = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode    = s_q.mode;
    assign act     = s_q.act;
    assign cmp_act = s_q.cmp;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter bit TOG_OK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             at_top,
    input  logic             tog_mode,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic [1:0]       act,
    input  logic             flag_clr,
    output logic             pin,
    output logic             flag
);
    typedef struct packed {
        logic wave;
        logic flag;
    } ch_st_t;

    ch_st_t s_d, s_q;
    logic   match;
    logic   tog_en;

    always_comb begin
        s_d    = s_q;
        match  = run && (count == cmp);
        tog_en = TOG_OK && tog_mode;
        case (act_e'(act))
            ACT_OFF: s_d.wave = 1'b0;
            ACT_TOG: begin
                if (!tog_en)    s_d.wave = 1'b0;
                else if (match) s_d.wave = ~s_q.wave;
            end
            ACT_NONINV: begin
                if (at_top)     s_d.wave = 1'b1;
                else if (match) s_d.wave = 1'b0;
            end
            default: begin
                if (at_top)     s_d.wave = 1'b0;
                else if (match) s_d.wave = 1'b1;
            end
        endcase
        if (match) begin
            s_d.flag = 1'b1;
        end else if (flag_clr) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pin  = s_q.wave;
    assign flag = s_q.flag;
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              pin_a,
    output logic              pin_b,
    output logic              ovf_flag,
    output logic              cmp_a_flag,
    output logic              cmp_b_flag
);
    logic [2:0]                   mode;
    logic [NUM_CH-1:0][1:0]       act;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
    logic                         run;
    logic                         at_top;
    logic [NUM_CH:0]              clr_v;
    logic [NUM_CH-1:0]            pin_v;
    logic [NUM_CH-1:0]            flag_v;

    assign clr_v = (wr_en && wr_addr == ADDR_CLR) ? wr_data[NUM_CH:0] : '0;

    pwm_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run(run), .at_top(at_top),
        .mode(mode), .act(act), .cmp_act(cmp_act)
    );

    pwm_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cmp_a(cmp_act[0]),
        .ovf_clr(clr_v[0]), .count(count), .run(run), .at_top(at_top),
        .ovf_flag(ovf_flag)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W), .TOG_OK(c == 0)) ch_i (
            .clk(clk), .rst_n(rst_n), .run(run), .at_top(at_top),
            .tog_mode(mode == MODE_CMPA), .count(count), .cmp(cmp_act[c]),
            .act(act[c]), .flag_clr(clr_v[c+1]), .pin(pin_v[c]),
            .flag(flag_v[c])
        );
    end

    assign pin_a      = pin_v[0];
    assign pin_b      = pin_v[1];
    assign cmp_a_flag = flag_v[0];
    assign cmp_b_flag = flag_v[1];
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [2:0]                    mode,
    input logic [NUM_CH-1:0][1:0]        act,
    input logic [NUM_CH-1:0][CNT_W-1:0]  cmp_act,
    input logic [CNT_W-1:0]              count,
    input logic                          pin_a,
    input logic                          pin_b,
    input logic                          ovf_flag,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [CNT_W-1:0]              wr_data
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    a_r2_wrap_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FIXED && count == CNT_MAX) |=> (count == '0));

    a_r3_wrap_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CMPA && count == cmp_act[0]) |=> (count == '0));

    a_r4_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_FIXED && mode != MODE_CMPA) |=> (count == '0));

    a_r5_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_FIXED && count == CNT_MAX) ||
         (mode == MODE_CMPA && count == cmp_act[0])) |=> ovf_flag);

    a_r6_noninv_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CMPA && act[1] == ACT_NONINV && count == cmp_act[0]) |=> pin_b);

    a_r7_inv_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CMPA && act[1] == ACT_INV && count == cmp_act[0]) |=> !pin_b);

    a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CMPA && act[0] == ACT_TOG && count == cmp_act[0]) |=> (pin_a != $past(pin_a)));

    a_r9_tog_b_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act[1] == ACT_TOG) |=> !pin_b);

    a_r10_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act[1] == ACT_OFF) |=> !pin_b);

    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_en && wr_addr == ADDR_CLR && wr_data[0])) |=> ovf_flag);
endmodule

bind pwm_timer8 pwm_timer8_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .act(act), .cmp_act(cmp_act),
    .count(count), .pin_a(pin_a), .pin_b(pin_b), .ovf_flag(ovf_flag),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/pwm_timer8_tb_top.sv
`timescale 1ns/1ps
module pwm_timer8_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] count;
    logic       pin_a, pin_b, ovf_flag, cmp_a_flag, cmp_b_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    logic [2:0] m_mode;
    logic [1:0] m_acta, m_actb;
    logic [7:0] m_bufa, m_bufb, m_cmpa, m_cmpb, m_cnt;
    logic       m_pa, m_pb, m_ovf, m_fa, m_fb;

    always #2.5 clk = ~clk;

    pwm_timer8 dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .pin_a(pin_a), .pin_b(pin_b),
        .ovf_flag(ovf_flag), .cmp_a_flag(cmp_a_flag), .cmp_b_flag(cmp_b_flag)
    );

    task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    function automatic logic next_wave(input logic [1:0] a, input logic cur,
                                       input logic top_ev, input logic m, input logic tog_ok);
        case (a)
            2'b00: return 1'b0;
            2'b01: return tog_ok ? (m ? ~cur : cur) : 1'b0;
            2'b10: return top_ev ? 1'b1 : (m ? 1'b0 : cur);
            default: return top_ev ? 1'b0 : (m ? 1'b1 : cur);
        endcase
    endfunction

    function automatic string pin_tag(input logic [1:0] a);
        case (a)
            2'b00: return "R10";
            2'b01: return "R8/R9";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model_reset();
        m_mode = '0; m_acta = '0; m_actb = '0; m_bufa = '0; m_bufb = '0;
        m_cmpa = '0; m_cmpb = '0; m_cnt = '0;
        m_pa = 1'b0; m_pb = 1'b0; m_ovf = 1'b0; m_fa = 1'b0; m_fb = 1'b0;
    endtask

    task automatic model_step();
        logic run, top_ev, ma, mb;
        logic [7:0] top;
        logic [2:0] clr;
        run    = (m_mode == 3'b011) || (m_mode == 3'b111);
        top    = (m_mode == 3'b111) ? m_cmpa : 8'hFF;
        top_ev = run && (m_cnt == top);
        ma     = run && (m_cnt == m_cmpa);
        mb     = run && (m_cnt == m_cmpb);
        clr    = (wr_en && wr_addr == 3'd4) ? wr_data[2:0] : 3'b000;
        m_pa   = next_wave(m_acta, m_pa, top_ev, ma, m_mode == 3'b111);
        m_pb   = next_wave(m_actb, m_pb, top_ev, mb, 1'b0);
        m_ovf  = top_ev ? 1'b1 : (m_ovf & ~clr[0]);
        m_fa   = ma ? 1'b1 : (m_fa & ~clr[1]);
        m_fb   = mb ? 1'b1 : (m_fb & ~clr[2]);
        m_cnt  = (!run || top_ev) ? 8'd0 : m_cnt + 8'd1;
        if (!run || top_ev) begin
            m_cmpa = m_bufa;
            m_cmpb = m_bufb;
        end
        if (wr_en) begin
            case (wr_addr)
                3'd0: m_mode = wr_data[2:0];
                3'd1: begin m_acta = wr_data[1:0]; m_actb = wr_data[3:2]; end
                3'd2: m_bufa = wr_data;
                3'd3: m_bufb = wr_data;
                default: ;
            endcase
        end
    endtask

    // One clock: drive inputs, advance the model, compare at the next falling edge.
    task automatic cycle(input logic we, input logic [2:0] a, input logic [7:0] d);
        string ctag;
        wr_en = we; wr_addr = a; wr_data = d;
        model_step();
        @(negedge clk);
        ctag = (m_mode == 3'b011) ? "R2" : ((m_mode == 3'b111) ? "R3" : "R4");
        check(count == m_cnt, ctag, count, m_cnt);
        check(pin_a == m_pa, pin_tag(m_acta), pin_a, m_pa);
        check(pin_b == m_pb, pin_tag(m_actb), pin_b, m_pb);
        check(ovf_flag == m_ovf, "R5/R12 ovf", ovf_flag, m_ovf);
        check(cmp_a_flag == m_fa, "R10/R12 flagA", cmp_a_flag, m_fa);
        check(cmp_b_flag == m_fb, "R10/R12 flagB", cmp_b_flag, m_fb);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 3'd0, 8'd0);
    endtask

    task automatic wait_count(input logic [7:0] v);
        for (int i = 0; i < 600 && count != v; i++) cycle(1'b0, 3'd0, 8'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi;
        int seed_v;
        logic prev;
        seed_v = $urandom(32'h5EED);
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(count == 8'd0 && !pin_a && !pin_b, "R1 outputs", {count, pin_a, pin_b}, 0);
        check(!ovf_flag && !cmp_a_flag && !cmp_b_flag, "R1 flags",
              {ovf_flag, cmp_a_flag, cmp_b_flag}, 0);
        rst_n = 1'b1;

        // Configure while halted (R4, R11 halted path)
        cycle(1'b1, 3'd1, 8'b0000_1001);   // A toggle, B non-inverting
        cycle(1'b1, 3'd2, 8'd4);
        cycle(1'b1, 3'd3, 8'd1);
        idle(3);
        check(count == 8'd0 && !ovf_flag, "R4 halted", count, 0);
        cycle(1'b1, 3'd0, 8'h07);
        idle(12);

        // R6: duty over one period equals B+1 of A+1 cycles
        wait_count(8'd0);
        hi = int'(pin_b);
        for (int i = 0; i < 4; i++) begin
            cycle(1'b0, 3'd0, 8'd0);
            hi += int'(pin_b);
        end
        check(hi == 2, "R6 duty", hi, 2);

        // R11: mid-period write of B leaves the current period alone
        wait_count(8'd1);
        cycle(1'b1, 3'd3, 8'd3);           // count now 2
        check(!pin_b, "R11 old duty kept", pin_b, 0);
        cycle(1'b0, 3'd0, 8'd0);           // count 3
        check(!pin_b, "R11 old duty kept", pin_b, 0);
        idle(2);                           // counts 4, 0
        wait_count(8'd3);
        check(pin_b, "R11 new duty", pin_b, 1);

        // R6 boundary: B equal to the limit keeps the pin high
        cycle(1'b1, 3'd3, 8'd4);
        idle(12);
        hi = 0;
        for (int i = 0; i < 5; i++) begin
            cycle(1'b0, 3'd0, 8'd0);
            hi += int'(pin_b);
        end
        check(hi == 5, "R6 full duty", hi, 5);

        // R8: compare A of 0 gives alternation every cycle
        cycle(1'b1, 3'd2, 8'd0);
        idle(12);
        prev = pin_a;
        for (int i = 0; i < 6; i++) begin
            cycle(1'b0, 3'd0, 8'd0);
            check(pin_a != prev, "R8 fastest toggle", pin_a, !prev);
            prev = pin_a;
        end

        // R2/R5/R9: fixed mode wraps at 0xFF, toggle on A gives low pin
        cycle(1'b1, 3'd4, 8'h07);
        cycle(1'b1, 3'd0, 8'h03);
        wait_count(8'hFF);
        cycle(1'b0, 3'd0, 8'd0);
        check(count == 8'd0 && ovf_flag, "R2/R5 fixed wrap", {count, ovf_flag}, 1);
        check(!pin_a, "R9 toggle off in fixed mode", pin_a, 0);

        // R12: clear then observe
        cycle(1'b1, 3'd4, 8'h01);
        check(!ovf_flag, "R12 clear", ovf_flag, 0);

        // R10: disconnected B still flags
        cycle(1'b1, 3'd1, 8'b0000_0010);
        cycle(1'b1, 3'd4, 8'h07);
        wait_count(8'd5);
        cycle(1'b0, 3'd0, 8'd0);
        check(!pin_b && cmp_b_flag, "R10 off with flag", {pin_b, cmp_b_flag}, 1);

        // Random phase
        for (int i = 0; i < 8000; i++) begin
            if ($urandom_range(15) == 0) begin
                logic [2:0] a;
                logic [7:0] d;
                a = 3'($urandom_range(4));
                d = 8'($urandom);
                if (a == 3'd0) begin
                    case ($urandom_range(3))
                        0: d = 8'h03;
                        1, 2: d = 8'h07;
                        default: d = 8'($urandom);
                    endcase
                end
                if (a == 3'd2) d = 8'($urandom_range(40));
                cycle(1'b1, a, d);
            end else begin
                cycle(1'b0, 3'd0, 8'd0);
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule